// File: doc/BRIEF.md
# Panel Serial Configuration Sequencer

This block writes configuration registers inside a display panel over a three-wire serial link. The link has an active-low select line, a bit clock that rests high, and a data line. Each write is one 16-bit frame made of an 8-bit register address and an 8-bit value. The host can request one arbitrary write. It can also trigger one of two built-in command lists: a five-write power-up list or a one-write power-down list.

A compile-time divider sets the bit rate. Every low phase and every high phase of the bit clock lasts the same number of system clocks. While a request or a list is being sent, `busy` is high and new requests are dropped. When the last frame ends, a single-cycle `done` pulse marks completion.

Top module: `panel_cfg_seq`

## Requirements
- R1: A frame carries exactly 16 bits, most significant bit first. Bits 15..8 hold the register address and bits 7..0 hold the value, so the panel sees 16 rising clock edges while select is low.
- R2: While no frame is in progress, select and clock are high and data is low. A frame opens when select falls, at which point the clock is high and data is low.
- R3: Within a frame, data changes only while the clock is low. Data holds steady for the whole of every high phase, so the panel samples it on the rising edge.
- R4: After the sixteenth rising edge, select returns high while the clock stays high.
- R5: The opening phase (select low, clock high), every low phase and every high phase of the clock each last HALF_DIV system clocks.
- R6: The power-up list sends, in this order: 0x05←0x1E, 0x05←0x5E, 0x07←0x8D, 0x13←0x01, 0x05←0x5F.
- R7: The power-down list sends one frame: 0x05←0x5E.
- R8: Between two frames of the same list, select stays high for at least HALF_DIV system clocks.
- R9: `busy` rises in the cycle after a request is accepted. It stays high until the last frame's closing gap ends. `done` is then high for exactly one cycle, with `busy` low in that cycle.
- R10: Requests seen while `busy` is high are dropped. They change neither the frames sent nor the frame count.
- R11: When requests arrive in the same cycle, power-down wins over power-up, and power-up wins over a single write.
- R12: An active-low asynchronous reset forces select high, clock high, data low, and `busy` and `done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req | input | 1 | Pulse: send one write of wr_addr/wr_val |
| wr_addr | input | 8 | Register address for a single write |
| wr_val | input | 8 | Value for a single write |
| on_req | input | 1 | Pulse: send the power-up list |
| off_req | input | 1 | Pulse: send the power-down list |
| ser_sel_n | output | 1 | Serial select, active low |
| ser_clk | output | 1 | Serial bit clock, idles high |
| ser_dat | output | 1 | Serial data, MSB first |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The embedded properties check the cycle-level line protocol on every cycle: a frame opens with the clock high and data low, data holds while the clock is high, a frame closes with the clock high, and phases move only on divider ticks. They also check that `done` is a lone pulse that follows `busy`, and that latched request data stays frozen while busy. Only the bench scenarios can show the payload itself: the decoded address and value order, the exact contents of both command lists, and the measured phase and gap lengths. The bench scenarios also cover simultaneous-request priority, requests dropped during a list, and recovery after a reset in mid-frame.

// File: rtl/panel_cfg_pkg.sv
package panel_cfg_pkg;

  localparam int ADDR_W  = 8;
  localparam int VAL_W   = 8;
  localparam int FRAME_W = ADDR_W + VAL_W;
  localparam int ON_LEN  = 5;
  localparam int OFF_LEN = 1;
  localparam int IDX_W   = $clog2(ON_LEN + 1);

  typedef enum logic [1:0] {
    LIST_ONE = 2'd0,
    LIST_ON  = 2'd1,
    LIST_OFF = 2'd2
  } list_e;

  typedef enum logic [2:0] {
    TX_IDLE = 3'd0,
    TX_LEAD = 3'd1,
    TX_LOW  = 3'd2,
    TX_HIGH = 3'd3,
    TX_GAP  = 3'd4
  } tx_state_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ISSUE = 2'd1,
    SQ_WAIT  = 2'd2
  } sq_state_e;

endpackage

// File: rtl/pcs_half_tick.sv
module pcs_half_tick #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = (HALF_DIV < 2) ? 1 : $clog2(HALF_DIV);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == CNT_LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LAST); // R5

endmodule

// File: rtl/pcs_frame_tx.sv
module pcs_frame_tx
  import panel_cfg_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame,
  output logic               sel_n,
  output logic               sclk,
  output logic               sdat,
  output logic               frame_done
);
  localparam int BIT_W = $clog2(FRAME_W);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_W - 1);

  tx_state_e          state_q, state_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [BIT_W-1:0]   bit_q, bit_d;
  logic               tick;

  pcs_half_tick #(.HALF_DIV(HALF_DIV)) i_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (state_q != TX_IDLE),
    .tick  (tick)
  );

  always_comb begin
    state_d = state_q;
    sh_d    = sh_q;
    bit_d   = bit_q;
    unique case (state_q)
      TX_IDLE: if (start) begin
        state_d = TX_LEAD;
        sh_d    = frame;
        bit_d   = '0;
      end
      TX_LEAD: if (tick) state_d = TX_LOW;
      TX_LOW:  if (tick) state_d = TX_HIGH;
      TX_HIGH: if (tick) begin
        if (bit_q == BIT_LAST) begin
          state_d = TX_GAP;
        end else begin
          state_d = TX_LOW;
          bit_d   = bit_q + 1'b1;
          sh_d    = {sh_q[FRAME_W-2:0], 1'b0};
        end
      end
      TX_GAP:  if (tick) state_d = TX_IDLE;
      default: state_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      sh_q    <= '0;
      bit_q   <= '0;
    end else begin
      state_q <= state_d;
      sh_q    <= sh_d;
      bit_q   <= bit_d;
    end
  end

  assign sel_n      = !((state_q == TX_LEAD) || (state_q == TX_LOW) || (state_q == TX_HIGH));
  assign sclk       = (state_q != TX_LOW);
  assign sdat       = ((state_q == TX_LOW) || (state_q == TX_HIGH)) ? sh_q[FRAME_W-1] : 1'b0;
  assign frame_done = (state_q == TX_GAP) && tick;

  AST_OPEN_WITH_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sel_n) |-> (sclk && !sdat)); // R2

  AST_DATA_HOLD_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && sclk && $past(sclk) && !$past(sel_n)) |-> $stable(sdat)); // R3

  AST_CLOSE_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_n) |-> (sclk && ($past(bit_q) == BIT_LAST))); // R4

  AST_PHASE_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q != $past(state_q)) && ($past(state_q) != TX_IDLE)) |-> $past(tick)); // R5

endmodule

// File: rtl/pcs_cmd_rom.sv
module pcs_cmd_rom
  import panel_cfg_pkg::*;
(
  input  list_e              sel,
  input  logic [IDX_W-1:0]   idx,
  input  logic [FRAME_W-1:0] one_word,
  output logic [FRAME_W-1:0] word,
  output logic               is_last
);
  always_comb begin
    word    = one_word;
    is_last = 1'b1;
    unique case (sel)
      LIST_ON: begin
        is_last = (idx == IDX_W'(ON_LEN - 1));
        case (idx)
          IDX_W'(0): word = {8'h05, 8'h1E};
          IDX_W'(1): word = {8'h05, 8'h5E};
          IDX_W'(2): word = {8'h07, 8'h8D};
          IDX_W'(3): word = {8'h13, 8'h01};
          default:   word = {8'h05, 8'h5F};
        endcase
      end
      LIST_OFF: begin
        is_last = (idx == IDX_W'(OFF_LEN - 1));
        word    = {8'h05, 8'h5E};
      end
      default: begin
        is_last = 1'b1;
        word    = one_word;
      end
    endcase
  end
endmodule

// File: rtl/panel_cfg_seq.sv
module panel_cfg_seq
  import panel_cfg_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [VAL_W-1:0]  wr_val,
  input  logic              on_req,
  input  logic              off_req,
  output logic              ser_sel_n,
  output logic              ser_clk,
  output logic              ser_dat,
  output logic              busy,
  output logic              done
);
  sq_state_e          sq_q, sq_d;
  list_e              sel_q, sel_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [FRAME_W-1:0] one_q;
  logic               one_en;
  logic               done_q, done_d;
  logic               accept;
  logic [FRAME_W-1:0] rom_word;
  logic               rom_last;
  logic               frame_done;

  assign accept = (sq_q == SQ_IDLE) && (wr_req || on_req || off_req);
  assign one_en = accept && wr_req;

  always_comb begin
    sq_d   = sq_q;
    sel_d  = sel_q;
    idx_d  = idx_q;
    done_d = 1'b0;
    unique case (sq_q)
      SQ_IDLE: if (accept) begin
        sq_d  = SQ_ISSUE;
        idx_d = '0;
        if (off_req)     sel_d = LIST_OFF;
        else if (on_req) sel_d = LIST_ON;
        else             sel_d = LIST_ONE;
      end
      SQ_ISSUE: sq_d = SQ_WAIT;
      SQ_WAIT: if (frame_done) begin
        if (rom_last) begin
          sq_d   = SQ_IDLE;
          done_d = 1'b1;
        end else begin
          sq_d  = SQ_ISSUE;
          idx_d = idx_q + 1'b1;
        end
      end
      default: sq_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq_q   <= SQ_IDLE;
      sel_q  <= LIST_ONE;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      sq_q   <= sq_d;
      sel_q  <= sel_d;
      idx_q  <= idx_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      one_q <= '0;
    else if (one_en) one_q <= {wr_addr, wr_val};
  end

  pcs_cmd_rom i_rom (
    .sel      (sel_q),
    .idx      (idx_q),
    .one_word (one_q),
    .word     (rom_word),
    .is_last  (rom_last)
  );

  pcs_frame_tx #(.HALF_DIV(HALF_DIV)) i_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (sq_q == SQ_ISSUE),
    .frame      (rom_word),
    .sel_n      (ser_sel_n),
    .sclk       (ser_clk),
    .sdat       (ser_dat),
    .frame_done (frame_done)
  );

  assign busy = (sq_q != SQ_IDLE);
  assign done = done_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R9

  AST_BUSY_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_req || on_req || off_req)); // R9

  AST_REQ_DROPPED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(sel_q) && $stable(one_q))); // R10

  AST_OFF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && off_req) |=> (sel_q == LIST_OFF)); // R11

endmodule

// File: tb/test_panel_cfg_seq.sv
module test_panel_cfg_seq;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 3;
  localparam int NVEC       = 6;

  // {kind[1:0], addr[7:0], val[7:0]}; kind 0 single, 1 power-up, 2 power-down, 3 all at once
  localparam logic [17:0] VEC [NVEC] = '{
    {2'd0, 8'hA5, 8'h3C},
    {2'd0, 8'h00, 8'hFF},
    {2'd0, 8'h80, 8'h01},
    {2'd1, 8'h00, 8'h00},
    {2'd2, 8'h00, 8'h00},
    {2'd3, 8'h77, 8'h22}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_req = 1'b0, on_req = 1'b0, off_req = 1'b0;
  logic [7:0] wr_addr = 8'h00, wr_val = 8'h00;
  logic       ser_sel_n, ser_clk, ser_dat, busy, done;

  int n_chk = 0;
  int n_fail = 0;

  panel_cfg_seq #(.HALF_DIV(HALF)) i_panel_cfg_seq (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(wr_addr), .wr_val(wr_val),
    .on_req(on_req), .off_req(off_req), .ser_sel_n(ser_sel_n), .ser_clk(ser_clk),
    .ser_dat(ser_dat), .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // serial line monitor, sampled on the falling system clock edge
  logic [15:0] cap  [64];
  int          capb [64];
  int          ncap = 0;
  logic [15:0] shv = '0;
  int bits = 0, run_len = 0, hi_run = 0;
  int err_open = 0, err_hold = 0, err_close = 0, err_phase = 0, err_gap = 0, err_done = 0;
  logic p_sel = 1'b1, p_sclk = 1'b1, p_dat = 1'b0, p_done = 1'b0, mid = 1'b0;

  always @(negedge clk) begin
    if (!rst_n) begin
      p_sel = 1'b1; p_sclk = 1'b1; p_dat = 1'b0; p_done = 1'b0;
      mid = 1'b0; run_len = 0; hi_run = 0;
    end else begin
      if (p_sel && !ser_sel_n) begin
        if (!(ser_clk && !ser_dat)) err_open++;
        if (mid && hi_run < HALF) err_gap++;
        bits = 0;
      end
      if ((ser_clk != p_sclk) || (ser_sel_n != p_sel)) begin
        if (!p_sel && run_len != HALF) err_phase++;
        run_len = 1;
      end else begin
        run_len++;
      end
      if (!p_sel && !ser_sel_n && p_sclk && ser_clk && (ser_dat != p_dat)) err_hold++;
      if (!ser_sel_n && !p_sclk && ser_clk) begin
        shv = {shv[14:0], ser_dat};
        bits++;
      end
      if (!p_sel && ser_sel_n) begin
        if (!ser_clk) err_close++;
        cap[ncap % 64]  = shv;
        capb[ncap % 64] = bits;
        ncap++;
        mid = 1'b1;
      end
      if (done && (p_done || busy)) err_done++;
      if (done) mid = 1'b0;
      if (ser_sel_n) hi_run++; else hi_run = 0;
      p_sel = ser_sel_n; p_sclk = ser_clk; p_dat = ser_dat; p_done = done;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(input logic [1:0] k, input logic [7:0] a,
                                           input logic [7:0] v, input int i);
    if (k == 2'd0) return {a, v};
    if (k == 2'd1) begin
      case (i)
        0: return 16'h051E;
        1: return 16'h055E;
        2: return 16'h078D;
        3: return 16'h1301;
        default: return 16'h055F;
      endcase
    end
    return 16'h055E;
  endfunction

  task automatic wait_done(input string req);
    bit seen = 1'b0;
    for (int c = 0; c < 3000 && !seen; c++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
    check(seen, req, 32'(seen), 32'd1);
  endtask

  task automatic run_req(input logic w, input logic on, input logic off, input logic [7:0] a,
                         input logic [7:0] v, input logic [1:0] ek, input string req);
    int base;
    int cnt;
    base = ncap;
    @(negedge clk); #1;
    wr_req = w; on_req = on; off_req = off; wr_addr = a; wr_val = v;
    @(negedge clk);
    wr_req = 1'b0; on_req = 1'b0; off_req = 1'b0;
    check(busy === 1'b1, "R9", 32'(busy), 32'd1);
    wait_done(req);
    cnt = (ek == 2'd1) ? 5 : 1;
    check((ncap - base) == cnt, req, 32'(ncap - base), 32'(cnt));
    for (int i = 0; i < cnt && i < (ncap - base); i++) begin
      check(cap[(base + i) % 64] == exp_word(ek, a, v, i), req,
            32'(cap[(base + i) % 64]), 32'(exp_word(ek, a, v, i)));
      check(capb[(base + i) % 64] == 16, "R1", 32'(capb[(base + i) % 64]), 32'd16);
    end
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    int base;
    // R12: lines idle and status low while reset is held
    #(CLK_PERIOD * 2 + 1);
    check({ser_sel_n, ser_clk, ser_dat, busy, done} == 5'b11000, "R12",
          32'({ser_sel_n, ser_clk, ser_dat, busy, done}), 32'h18);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check({ser_sel_n, ser_clk, ser_dat} == 3'b110, "R2",
          32'({ser_sel_n, ser_clk, ser_dat}), 32'h6);

    for (int n = 0; n < NVEC; n++) begin
      logic [1:0] k;
      k = VEC[n][17:16];
      if (k == 2'd3)
        run_req(1'b1, 1'b1, 1'b1, VEC[n][15:8], VEC[n][7:0], 2'd2, "R11");
      else
        run_req(k == 2'd0, k == 2'd1, k == 2'd2, VEC[n][15:8], VEC[n][7:0], k,
                (k == 2'd1) ? "R6" : (k == 2'd2) ? "R7" : "R1");
    end

    // R11: power-up beats a single write
    run_req(1'b1, 1'b1, 1'b0, 8'h42, 8'h24, 2'd1, "R11");

    // R10: requests during a running list are dropped
    base = ncap;
    @(negedge clk); #1 on_req = 1'b1;
    @(negedge clk); on_req = 1'b0;
    repeat (40) @(negedge clk);
    #1 wr_req = 1'b1; wr_addr = 8'hAA; wr_val = 8'h55; off_req = 1'b1;
    @(negedge clk); wr_req = 1'b0; off_req = 1'b0;
    wait_done("R10");
    check((ncap - base) == 5, "R10", 32'(ncap - base), 32'd5);
    for (int i = 0; i < 5; i++)
      check(cap[(base + i) % 64] == exp_word(2'd1, 8'h00, 8'h00, i), "R10",
            32'(cap[(base + i) % 64]), 32'(exp_word(2'd1, 8'h00, 8'h00, i)));
    repeat (200) @(negedge clk);
    check((ncap - base) == 5, "R10", 32'(ncap - base), 32'd5);
    check(busy == 1'b0, "R10", 32'(busy), 32'd0);

    // R12: reset in mid-frame returns lines to idle at once
    @(negedge clk); #1 wr_req = 1'b1; wr_addr = 8'h12; wr_val = 8'h34;
    @(negedge clk); wr_req = 1'b0;
    repeat (40) @(negedge clk);
    check(ser_sel_n == 1'b0, "R12", 32'(ser_sel_n), 32'd0);
    #1 rst_n = 1'b0;
    #1;
    check({ser_sel_n, ser_clk, ser_dat, busy, done} == 5'b11000, "R12",
          32'({ser_sel_n, ser_clk, ser_dat, busy, done}), 32'h18);
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    run_req(1'b1, 1'b0, 1'b0, 8'hC3, 8'h96, 2'd0, "R12");

    // aggregate line-protocol checks from the monitor
    check(err_open == 0,  "R2", 32'(err_open),  32'd0);
    check(err_hold == 0,  "R3", 32'(err_hold),  32'd0);
    check(err_close == 0, "R4", 32'(err_close), 32'd0);
    check(err_phase == 0, "R5", 32'(err_phase), 32'd0);
    check(err_gap == 0,   "R8", 32'(err_gap),   32'd0);
    check(err_done == 0,  "R9", 32'(err_done),  32'd0);
    finish_run();
  end
endmodule